// File: doc/BRIEF.md
# Flash Driver Serial Register Interface

This block is the two-wire serial target for a camera-flash LED driver. It watches an I2C bus (clock and data, with open-drain data modelled as a separate drive-low output and a sampled input), decodes write and read transactions aimed at its own address, and keeps four byte-wide registers. Their fields go straight to the current-regulation and timing logic: a high-power LED current code, an indicator LED current code, a timer configuration byte and a software strobe byte. A fourth register collects fault events raised by the rest of the driver and holds an active-low interrupt until software clears it.

A write transaction is: start, write address, subaddress byte, one data byte, stop. A read transaction is: start, write address, subaddress byte, repeated start, read address, one byte from the target, no-acknowledge from the controller, stop. The subaddress is kept between transactions. Everything runs on the system clock; both bus lines pass through a synchroniser and edges are found by comparison with the previous sample.

The bus has no back-pressure at this edge: the target never holds the clock low, so the controller sets the pace, and the system clock must be fast enough to see every bus phase (a few clock cycles per half bit). The register outputs are plain levels, valid in every cycle.

Top module: `flash_i2c_regif`

## Requirements
- R1: Only the address bytes 0x60 (write) and 0x61 (read), i.e. the 7-bit address 0x30, are acknowledged; any other address byte gets no acknowledge and the rest of that transaction has no effect on any register.
- R2: In a write, the address byte, the subaddress byte and the data byte are each acknowledged by pulling data low during the ninth clock, and the data byte is stored in the register the subaddress selects.
- R3: In a read, after the repeated start and address 0x61 is acknowledged, the target drives the selected register most significant bit first over eight clocks, then releases data so the controller can answer.
- R4: Subaddress 0 selects output select, 1 the timer configuration byte (timer output), 2 the software strobe byte (strobe output) and 3 the fault register.
- R5: Output select carries the high-power LED code in bits 7:3 and the indicator LED code in bits 2:0.
- R6: A fault event on input bit k sets fault register bit k (bits above the number of fault inputs read zero); set bits stay set, and the interrupt output is low while any fault bit is set.
- R7: Writing 0x00 to output select clears every fault bit and releases the interrupt in the next cycle; writing any nonzero value to output select leaves the fault bits unchanged. A fault event in the same cycle as the clearing write is kept.
- R8: Writes to the fault register and to subaddresses 4 to 255 are acknowledged but change nothing; reads of subaddresses 4 to 255 return 0x00.
- R9: After reset all four registers are zero, the interrupt output is high and data is released.
- R10: The target changes its data drive only while the bus clock is low and never drives the clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset (power-on or undervoltage) |
| scl_i | input | 1 | Bus clock as seen on the pin |
| sda_i | input | 1 | Bus data as seen on the pin |
| sda_drive_low_o | output | 1 | 1 pulls the bus data line low |
| fault_evt_i | input | NUM_FAULTS | One-cycle fault event pulses from the driver |
| hp_code_o | output | 5 | High-power LED current code |
| ind_code_o | output | 3 | Indicator LED current code |
| timer_reg_o | output | 8 | Timer configuration byte |
| strobe_reg_o | output | 8 | Software strobe byte |
| irq_n_o | output | 1 | Active-low interrupt, low while a fault is held |

## Verification
The bench builds the block with its defaults: target address 0x30, a two-stage synchroniser and four fault inputs, so fault bit 2 is reachable and bits 7:4 of the fault byte must read zero. A bus quarter-period of eight system clocks leaves the synchroniser latency well inside each bus phase, which lets the bench sample acknowledge and read bits in the middle of the clock-high time. A monitor watches every change of the data drive against the bus clock, and the directed transactions cover a foreign address, the unused and read-only subaddresses, and the clear-by-zero side effect against a nonzero write.

// File: rtl/flash_i2c_pkg.sv
package flash_i2c_pkg;

  typedef enum logic [2:0] {
    ENG_IDLE,
    ENG_ADDR,
    ENG_SUB,
    ENG_WDATA,
    ENG_RDATA,
    ENG_MACK,
    ENG_DONE
  } eng_state_e;

  localparam int BYTE_W = 8;
  localparam int CNT_W  = 4;

  localparam logic [BYTE_W-1:0] SUB_OUTSEL = 8'd0;
  localparam logic [BYTE_W-1:0] SUB_TIMER  = 8'd1;
  localparam logic [BYTE_W-1:0] SUB_STROBE = 8'd2;
  localparam logic [BYTE_W-1:0] SUB_FAULT  = 8'd3;

endpackage

// File: rtl/flash_i2c_sync.sv
module flash_i2c_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_q,
  output logic sda_q,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_ff;
  logic [STAGES-1:0] sda_ff;
  logic              scl_p;
  logic              sda_p;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_ff[g] <= 1'b1;
          sda_ff[g] <= 1'b1;
        end else if (g == 0) begin
          scl_ff[g] <= scl_i;
          sda_ff[g] <= sda_i;
        end else begin
          scl_ff[g] <= scl_ff[(g == 0) ? 0 : g-1];
          sda_ff[g] <= sda_ff[(g == 0) ? 0 : g-1];
        end
      end
    end
  endgenerate

  assign scl_q = scl_ff[STAGES-1];
  assign sda_q = sda_ff[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_q;
      sda_p <= sda_q;
    end
  end

  assign scl_rise  = scl_q & ~scl_p;
  assign scl_fall  = ~scl_q & scl_p;
  assign start_det = scl_q & scl_p & sda_p & ~sda_q;
  assign stop_det  = scl_q & scl_p & ~sda_p & sda_q;

endmodule

// File: rtl/flash_i2c_engine.sv
module flash_i2c_engine
  import flash_i2c_pkg::*;
#(
  parameter logic [6:0] TGT_ADDR = 7'h30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              sda_q,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              sda_low,
  output logic [BYTE_W-1:0] sub_q,
  output logic              wr_en,
  output logic [BYTE_W-1:0] wr_data
);

  localparam logic [BYTE_W-1:0] ADDR_WR = {TGT_ADDR, 1'b0};
  localparam logic [BYTE_W-1:0] ADDR_RD = {TGT_ADDR, 1'b1};

  eng_state_e        st;
  logic [CNT_W-1:0]  bitcnt;
  logic [BYTE_W-2:0] sh;
  logic [BYTE_W-1:0] tx;
  logic              ack_arm;
  logic              in_ack;
  logic [BYTE_W-1:0] byte_in;

  assign byte_in = {sh, sda_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ENG_IDLE;
      bitcnt  <= '0;
      sh      <= '0;
      tx      <= '0;
      ack_arm <= 1'b0;
      in_ack  <= 1'b0;
      sda_low <= 1'b0;
      sub_q   <= '0;
      wr_en   <= 1'b0;
      wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_det) begin
        st      <= ENG_ADDR;
        bitcnt  <= '0;
        sda_low <= 1'b0;
        ack_arm <= 1'b0;
        in_ack  <= 1'b0;
      end else if (stop_det) begin
        st      <= ENG_IDLE;
        sda_low <= 1'b0;
        ack_arm <= 1'b0;
        in_ack  <= 1'b0;
      end else if (scl_fall) begin
        if (ack_arm) begin
          sda_low <= 1'b1;
          ack_arm <= 1'b0;
          in_ack  <= 1'b1;
        end else if (in_ack) begin
          in_ack  <= 1'b0;
          sda_low <= (st == ENG_RDATA) ? ~tx[BYTE_W-1] : 1'b0;
        end else if (st == ENG_RDATA) begin
          if (bitcnt == CNT_W'(BYTE_W)) begin
            sda_low <= 1'b0;
            st      <= ENG_MACK;
          end else begin
            tx      <= {tx[BYTE_W-2:0], 1'b0};
            sda_low <= ~tx[BYTE_W-2];
          end
        end else begin
          sda_low <= 1'b0;
        end
      end else if (scl_rise && !in_ack) begin
        case (st)
          ENG_ADDR, ENG_SUB, ENG_WDATA: begin
            sh <= byte_in[BYTE_W-2:0];
            if (bitcnt == CNT_W'(BYTE_W-1)) begin
              bitcnt <= '0;
              if (st == ENG_ADDR) begin
                if (byte_in == ADDR_WR) begin
                  ack_arm <= 1'b1;
                  st      <= ENG_SUB;
                end else if (byte_in == ADDR_RD) begin
                  ack_arm <= 1'b1;
                  tx      <= rd_data;
                  st      <= ENG_RDATA;
                end else begin
                  st <= ENG_DONE;
                end
              end else if (st == ENG_SUB) begin
                sub_q   <= byte_in;
                ack_arm <= 1'b1;
                st      <= ENG_WDATA;
              end else begin
                wr_en   <= 1'b1;
                wr_data <= byte_in;
                ack_arm <= 1'b1;
                st      <= ENG_DONE;
              end
            end else begin
              bitcnt <= bitcnt + 1'b1;
            end
          end
          ENG_RDATA: bitcnt <= bitcnt + 1'b1;
          ENG_MACK:  st <= ENG_DONE;
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/flash_regfile.sv
module flash_regfile
  import flash_i2c_pkg::*;
#(
  parameter int NUM_FAULTS = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [BYTE_W-1:0]     sub,
  input  logic [BYTE_W-1:0]     wr_data,
  input  logic [NUM_FAULTS-1:0] fault_evt,
  output logic [BYTE_W-1:0]     rd_data,
  output logic [BYTE_W-1:0]     out_sel,
  output logic [BYTE_W-1:0]     timer_q,
  output logic [BYTE_W-1:0]     strobe_q,
  output logic [BYTE_W-1:0]     fault_byte
);

  logic [NUM_FAULTS-1:0] flt_q;
  logic                  clr_faults;

  assign clr_faults = wr_en && (sub == SUB_OUTSEL) && (wr_data == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_sel  <= '0;
      timer_q  <= '0;
      strobe_q <= '0;
      flt_q    <= '0;
    end else begin
      if (wr_en) begin
        case (sub)
          SUB_OUTSEL: out_sel  <= wr_data;
          SUB_TIMER:  timer_q  <= wr_data;
          SUB_STROBE: strobe_q <= wr_data;
          default: ;
        endcase
      end
      flt_q <= (clr_faults ? '0 : flt_q) | fault_evt;
    end
  end

  always_comb begin
    fault_byte = '0;
    fault_byte[NUM_FAULTS-1:0] = flt_q;
  end

  always_comb begin
    case (sub)
      SUB_OUTSEL: rd_data = out_sel;
      SUB_TIMER:  rd_data = timer_q;
      SUB_STROBE: rd_data = strobe_q;
      SUB_FAULT:  rd_data = fault_byte;
      default:    rd_data = '0;
    endcase
  end

endmodule

// File: rtl/flash_i2c_regif.sv
module flash_i2c_regif
  import flash_i2c_pkg::*;
#(
  parameter logic [6:0] TGT_ADDR    = 7'h30,
  parameter int         SYNC_STAGES = 2,
  parameter int         NUM_FAULTS  = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_drive_low_o,
  input  logic [NUM_FAULTS-1:0] fault_evt_i,
  output logic [4:0]            hp_code_o,
  output logic [2:0]            ind_code_o,
  output logic [BYTE_W-1:0]     timer_reg_o,
  output logic [BYTE_W-1:0]     strobe_reg_o,
  output logic                  irq_n_o
);

  logic              scl_q, sda_q;
  logic              scl_rise, scl_fall, start_det, stop_det;
  logic [BYTE_W-1:0] rd_data, sub_q, wr_data, out_sel, fault_byte;
  logic              wr_en;

  flash_i2c_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .scl_q    (scl_q),
    .sda_q    (sda_q),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det)
  );

  flash_i2c_engine #(.TGT_ADDR(TGT_ADDR)) eng_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det),
    .sda_q    (sda_q),
    .rd_data  (rd_data),
    .sda_low  (sda_drive_low_o),
    .sub_q    (sub_q),
    .wr_en    (wr_en),
    .wr_data  (wr_data)
  );

  flash_regfile #(.NUM_FAULTS(NUM_FAULTS)) regs_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .sub       (sub_q),
    .wr_data   (wr_data),
    .fault_evt (fault_evt_i),
    .rd_data   (rd_data),
    .out_sel   (out_sel),
    .timer_q   (timer_reg_o),
    .strobe_q  (strobe_reg_o),
    .fault_byte(fault_byte)
  );

  assign hp_code_o  = out_sel[7:3];
  assign ind_code_o = out_sel[2:0];
  assign irq_n_o    = ~|fault_byte;

endmodule

// File: rtl/flash_i2c_regif_chk.sv
module flash_i2c_regif_chk #(
  parameter int NF = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_q,
  input logic          sda_drive_low_o,
  input logic          wr_en,
  input logic [7:0]    sub_q,
  input logic [7:0]    wr_data,
  input logic [7:0]    out_sel,
  input logic [7:0]    fault_byte,
  input logic [NF-1:0] fault_evt_i,
  input logic          irq_n_o
);

  logic clr_wr;
  assign clr_wr = wr_en && (sub_q == 8'd0) && (wr_data == 8'd0);

  assert_fault_raises_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|fault_evt_i) |=> !irq_n_o);

  assert_irq_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_n_o && !clr_wr) |=> !irq_n_o);

  assert_zero_write_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && fault_evt_i == '0) |=> irq_n_o);

  assert_outsel_only_by_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && sub_q == 8'd0) |=> $stable(out_sel));

  assert_fault_write_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sub_q == 8'd3 && fault_evt_i == '0) |=> $stable(fault_byte));

  assert_sda_moves_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_drive_low_o) |-> !scl_q);

endmodule

bind flash_i2c_regif flash_i2c_regif_chk #(.NF(NUM_FAULTS)) chk_i (
  .clk            (clk),
  .rst_n          (rst_n),
  .scl_q          (scl_q),
  .sda_drive_low_o(sda_drive_low_o),
  .wr_en          (wr_en),
  .sub_q          (sub_q),
  .wr_data        (wr_data),
  .out_sel        (out_sel),
  .fault_byte     (fault_byte),
  .fault_evt_i    (fault_evt_i),
  .irq_n_o        (irq_n_o)
);

// File: tb/flash_i2c_regif_tb.sv
module flash_i2c_regif_tb_top;

  localparam int Q = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1;
  logic       m_low = 1'b0;
  logic       dut_low;
  logic       sda_line;
  logic [3:0] fevt = '0;
  logic [4:0] hp;
  logic [2:0] ind;
  logic [7:0] tmr, strb;
  logic       irq_n;

  int tests = 0;
  int fails = 0;
  int r10_viol = 0;

  always #10 clk = ~clk;

  assign sda_line = ~(m_low | dut_low);

  flash_i2c_regif dut_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .scl_i          (scl),
    .sda_i          (sda_line),
    .sda_drive_low_o(dut_low),
    .fault_evt_i    (fevt),
    .hp_code_o      (hp),
    .ind_code_o     (ind),
    .timer_reg_o    (tmr),
    .strobe_reg_o   (strb),
    .irq_n_o        (irq_n)
  );

  // R10 monitor: target drive may only move while the bus clock is low
  logic prev_low = 1'b0;
  always @(negedge clk) begin
    if (rst_n && (dut_low !== prev_low) && scl) r10_viol++;
    prev_low <= dut_low;
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic hc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    if (scl) begin
      m_low = 1'b1; hc(2*Q); scl = 1'b0; hc(Q);
    end else begin
      m_low = 1'b0; hc(Q); scl = 1'b1; hc(2*Q);
      m_low = 1'b1; hc(2*Q); scl = 1'b0; hc(Q);
    end
  endtask

  task automatic bus_stop();
    m_low = 1'b1; hc(Q); scl = 1'b1; hc(2*Q); m_low = 1'b0; hc(2*Q);
  endtask

  task automatic put_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_low = ~b[i]; hc(Q); scl = 1'b1; hc(2*Q); scl = 1'b0; hc(Q);
    end
    m_low = 1'b0; hc(Q); scl = 1'b1; hc(Q);
    ack = ~sda_line;
    hc(Q); scl = 1'b0; hc(Q);
  endtask

  task automatic get_byte(output logic [7:0] b, input logic nack);
    m_low = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      hc(Q); scl = 1'b1; hc(Q); b[i] = sda_line; hc(Q); scl = 1'b0;
    end
    hc(Q); m_low = ~nack; hc(Q); scl = 1'b1; hc(2*Q); scl = 1'b0; hc(Q);
    m_low = 1'b0;
  endtask

  task automatic wr_reg(input logic [7:0] sub, input logic [7:0] d, output logic [2:0] acks);
    logic a;
    bus_start();
    put_byte(8'h60, a); acks[2] = a;
    put_byte(sub, a);   acks[1] = a;
    put_byte(d, a);     acks[0] = a;
    bus_stop();
  endtask

  task automatic rd_reg(input logic [7:0] sub, output logic [7:0] d, output logic [2:0] acks);
    logic a;
    bus_start();
    put_byte(8'h60, a); acks[2] = a;
    put_byte(sub, a);   acks[1] = a;
    bus_start();
    put_byte(8'h61, a); acks[0] = a;
    get_byte(d, 1'b1);
    bus_stop();
  endtask

  task automatic t_reset();
    chk("R9", "hp code", 32'(hp), 0);
    chk("R9", "ind code", 32'(ind), 0);
    chk("R9", "timer", 32'(tmr), 0);
    chk("R9", "strobe", 32'(strb), 0);
    chk("R9", "irq_n", 32'(irq_n), 1);
    chk("R9", "sda released", 32'(dut_low), 0);
  endtask

  task automatic t_write_fields();
    logic [2:0] ak;
    wr_reg(8'h00, 8'hAB, ak);
    chk("R2", "write acks", 32'(ak), 3'b111);
    chk("R5", "hp code from 0xAB", 32'(hp), 5'd21);
    chk("R5", "ind code from 0xAB", 32'(ind), 3'd3);
    wr_reg(8'h01, 8'h5C, ak);
    chk("R4", "timer byte", 32'(tmr), 8'h5C);
    wr_reg(8'h02, 8'h01, ak);
    chk("R4", "strobe byte", 32'(strb), 8'h01);
    chk("R4", "timer kept", 32'(tmr), 8'h5C);
  endtask

  task automatic t_read_back();
    logic [2:0] ak;
    logic [7:0] d;
    rd_reg(8'h01, d, ak);
    chk("R3", "read acks", 32'(ak), 3'b111);
    chk("R3", "read timer", 32'(d), 8'h5C);
    rd_reg(8'h00, d, ak);
    chk("R3", "read outsel", 32'(d), 8'hAB);
    rd_reg(8'h02, d, ak);
    chk("R4", "read strobe", 32'(d), 8'h01);
  endtask

  task automatic t_foreign_addr();
    logic a;
    bus_start();
    put_byte(8'h62, a);
    chk("R1", "ack on 0x62", 32'(a), 0);
    put_byte(8'h01, a);
    put_byte(8'h00, a);
    bus_stop();
    bus_start();
    put_byte(8'h40, a);
    chk("R1", "ack on 0x40", 32'(a), 0);
    bus_stop();
    chk("R1", "timer untouched", 32'(tmr), 8'h5C);
  endtask

  task automatic t_faults();
    logic [2:0] ak;
    logic [7:0] d;
    @(negedge clk); fevt = 4'b0100; @(negedge clk); fevt = '0; hc(2);
    chk("R6", "irq_n after event", 32'(irq_n), 0);
    rd_reg(8'h03, d, ak);
    chk("R6", "fault byte", 32'(d), 8'h04);
    wr_reg(8'h03, 8'hFF, ak);
    chk("R8", "fault write acks", 32'(ak), 3'b111);
    rd_reg(8'h03, d, ak);
    chk("R8", "fault byte after write", 32'(d), 8'h04);
    wr_reg(8'h09, 8'h77, ak);
    chk("R8", "unused write acks", 32'(ak), 3'b111);
    chk("R8", "timer after unused write", 32'(tmr), 8'h5C);
    chk("R8", "strobe after unused write", 32'(strb), 8'h01);
    chk("R8", "hp after unused write", 32'(hp), 5'd21);
    rd_reg(8'h09, d, ak);
    chk("R8", "unused read", 32'(d), 8'h00);
  endtask

  task automatic t_clear();
    logic [2:0] ak;
    logic [7:0] d;
    wr_reg(8'h00, 8'h08, ak);
    chk("R7", "irq_n after nonzero write", 32'(irq_n), 0);
    chk("R5", "hp code from 0x08", 32'(hp), 5'd1);
    wr_reg(8'h00, 8'h00, ak);
    chk("R7", "irq_n after zero write", 32'(irq_n), 1);
    rd_reg(8'h03, d, ak);
    chk("R7", "fault byte cleared", 32'(d), 8'h00);
    chk("R7", "hp code zero", 32'(hp), 5'd0);
  endtask

  initial begin
    hc(5);
    rst_n = 1'b1;
    hc(5);
    t_reset();
    t_write_fields();
    t_read_back();
    t_foreign_addr();
    t_faults();
    t_clear();
    chk("R10", "drive changes with scl high", 32'(r10_viol), 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL R9 watchdog actual=timeout expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule